// File: doc/BRIEF.md
# Interrupt-on-change port monitor

This block watches a general-purpose input port and raises one shared change flag whenever an enabled, digitally configured pin no longer matches the value that software last saw. That value is a snapshot. It is refreshed on every bus read or write of the port, not on every clock. A persistent mismatch therefore keeps re-asserting the flag until software has accessed the port and then cleared the flag.

Pins pass through a synchroniser before use. Pins marked as analog read back as zero and never take part in change detection. A warm reset returns the configuration to its power-on values but keeps the snapshot. As a result, a difference that exists across the warm reset sets the flag again as soon as detection is re-enabled. A wake output gates the flag with a global enable, without any register, so it stays usable while the core clock is stopped.

Top module: `ioc_port_monitor`

## Requirements
- R1: After power-on reset (`por_n` low, synchronous), `flag_o` is 0. All change enables are 0. All analog selects are 1, so `port_rdata` reads 0. The snapshot is 0.
- R2: `port_rdata` equals the synchronised pin value with every analog-selected bit forced to 0. A pin change driven before clock edge k is visible after edge k+1.
- R3: When an enabled, digitally selected pin differs from its snapshot bit, `flag_o` is 1 after edge k+2, where the pin change was driven before edge k. Any single pin is enough to set the flag.
- R4: A pin whose enable bit is 0 never sets the flag. A pin whose analog-select bit is 1 also never sets it.
- R5: While a mismatch persists and the port is not accessed, the flag is set again on every cycle. A clear request has no lasting effect in that case.
- R6: A read (`port_rd`) or write (`port_wr`) of the port loads the snapshot with the current `port_rdata`. This ends the mismatch. An access by itself does not clear the flag. A `flag_clr` pulse sampled at edge k clears the flag after edge k+1.
- R7: If the clear takes effect at an edge where a mismatch is present, the flag stays 1 (set wins over clear).
- R8: A warm reset (`warm_rst_n` low) clears the flag, the enables (to 0) and the analog selects (to all 1) while leaving the snapshot unchanged. Power-on reset also clears the snapshot.
- R9: `wake_o` is `flag_o` gated by `gie_i`, with no clock edge between a change of `gie_i` and `wake_o`.
- R10: A port access ignores any mismatch in the same cycle. A pin change that reaches the synchronised value in exactly the cycle of the read is therefore absorbed into the snapshot and does not set the flag. A read one cycle later does not absorb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| warm_rst_n | input | 1 | Warm (pin or supply-dip) reset, active low, synchronous |
| pin_i | input | W | Asynchronous port pin levels |
| ien_we | input | 1 | Write strobe for the change-enable register |
| ien_wdata | input | W | New change-enable bits, 1 = detection on |
| asel_we | input | 1 | Write strobe for the analog-select register |
| asel_wdata | input | W | New analog-select bits, 1 = analog |
| port_rd | input | 1 | Bus read of the port (single-cycle strobe) |
| port_wr | input | 1 | Bus write of the port (single-cycle strobe) |
| flag_clr | input | 1 | Flag-clear write strobe |
| gie_i | input | 1 | Global change-interrupt enable for the wake request |
| port_rdata | output | W | Digital read value of the port |
| flag_o | output | 1 | Shared change flag |
| wake_o | output | 1 | Wake request, flag gated by `gie_i` |

## Verification
The properties assume that the bus strobes and the flag-clear strobe are clean synchronous levels. They also assume that the enable and analog-select registers change only through their write strobes. The stimulus meets this by driving every control on the falling clock edge as a one-cycle pulse. Pins are held steady for at least three cycles between changes, except in the deliberate coincident-read case. The properties also take power-on reset to be applied before any check is meaningful, so the bench starts with `por_n` low for several cycles.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    // Default port width and synchroniser depth shared by the block.
    localparam int unsigned IOC_PORT_W   = 8;
    localparam int unsigned IOC_SYNC_DEP = 2;

    // Kind of bus access seen in a cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } acc_kind_e;

    function automatic acc_kind_e decode_access(input logic rd, input logic wr);
        if (wr)      return ACC_WRITE;
        else if (rd) return ACC_READ;
        else         return ACC_IDLE;
    endfunction

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < int'(STAGES); s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[LAST];
endmodule

// File: rtl/ioc_cfg.sv
module ioc_cfg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         warm_rst_n,
    input  logic         ien_we,
    input  logic [W-1:0] ien_wdata,
    input  logic         asel_we,
    input  logic [W-1:0] asel_wdata,
    output logic [W-1:0] ien_q,
    output logic [W-1:0] asel_q
);
    typedef struct packed {
        logic [W-1:0] ien;
        logic [W-1:0] asel;
    } cfg_t;

    localparam cfg_t CFG_RST = '{ien: '0, asel: '1};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (ien_we)  cfg_d.ien  = ien_wdata;
        if (asel_we) cfg_d.asel = asel_wdata;
        if (!warm_rst_n) cfg_d = CFG_RST;
    end

    always_ff @(posedge clk) begin
        if (!por_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign ien_q  = cfg_q.ien;
    assign asel_q = cfg_q.asel;
endmodule

// File: rtl/ioc_port_monitor.sv
module ioc_port_monitor
    import ioc_pkg::*;
#(
    parameter int unsigned W      = IOC_PORT_W,
    parameter int unsigned STAGES = IOC_SYNC_DEP
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         warm_rst_n,
    input  logic [W-1:0] pin_i,
    input  logic         ien_we,
    input  logic [W-1:0] ien_wdata,
    input  logic         asel_we,
    input  logic [W-1:0] asel_wdata,
    input  logic         port_rd,
    input  logic         port_wr,
    input  logic         flag_clr,
    input  logic         gie_i,
    output logic [W-1:0] port_rdata,
    output logic         flag_o,
    output logic         wake_o
);
    typedef struct packed {
        logic [W-1:0] snap;
        logic         flag;
        logic         clr_pend;
    } mon_t;

    logic [W-1:0] sync_q;
    logic [W-1:0] ien_q;
    logic [W-1:0] asel_q;
    logic [W-1:0] rd_val;
    logic [W-1:0] diff;
    logic         any_diff;
    acc_kind_e    acc;
    mon_t         st_d, st_q;

    ioc_sync #(.W(W), .STAGES(STAGES)) sync_i (
        .clk   (clk),
        .por_n (por_n),
        .din   (pin_i),
        .dout  (sync_q)
    );

    ioc_cfg #(.W(W)) cfg_i (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .ien_we     (ien_we),
        .ien_wdata  (ien_wdata),
        .asel_we    (asel_we),
        .asel_wdata (asel_wdata),
        .ien_q      (ien_q),
        .asel_q     (asel_q)
    );

    always_comb begin
        st_d     = st_q;
        acc      = decode_access(port_rd, port_wr);
        rd_val   = sync_q & ~asel_q;
        diff     = (rd_val ^ st_q.snap) & ien_q & ~asel_q;
        any_diff = |diff;

        if (acc != ACC_IDLE) st_d.snap = rd_val;

        st_d.flag     = (any_diff && acc == ACC_IDLE) || (st_q.flag && !st_q.clr_pend);
        st_d.clr_pend = flag_clr;

        if (!warm_rst_n) begin
            st_d.snap     = st_q.snap;
            st_d.flag     = 1'b0;
            st_d.clr_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign port_rdata = rd_val;
    assign flag_o     = st_q.flag;
    assign wake_o     = st_q.flag & gie_i;
endmodule

// File: rtl/ioc_port_monitor_chk.sv
module ioc_port_monitor_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         por_n,
    input logic         warm_rst_n,
    input logic         port_rd,
    input logic         port_wr,
    input logic         flag_clr,
    input logic [W-1:0] port_rdata,
    input logic         flag_o,
    input logic [W-1:0] sync_val,
    input logic [W-1:0] snap_val,
    input logic [W-1:0] en_val,
    input logic [W-1:0] ana_val
);
    logic mism;
    logic seen_q;
    logic por_prev_q;

    assign mism = |((sync_val & ~ana_val ^ snap_val) & en_val & ~ana_val);

    always_ff @(posedge clk) begin
        seen_q     <= 1'b1;
        por_prev_q <= por_n;
    end

    always @(posedge clk) begin
        if (seen_q && !por_prev_q) begin
            assert_por_state_R1: assert (flag_o == 1'b0 && snap_val == '0 &&
                                         en_val == '0 && ana_val == '1)
                else $error("power-on state wrong");
        end
    end

    assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!flag_o && (port_rd || port_wr || !mism)) |=> !flag_o);

    assert_mismatch_sets_R5: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        (mism && !port_rd && !port_wr) |=> flag_o);

    assert_access_refresh_R6: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        (port_rd || port_wr) |=> (snap_val == $past(port_rdata)));

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
        ($past(flag_clr && warm_rst_n && por_n) && !mism) |=> !flag_o);

    assert_warm_keeps_snap_R8: assert property (@(posedge clk) disable iff (!por_n)
        !warm_rst_n |=> $stable(snap_val));
endmodule

bind ioc_port_monitor ioc_port_monitor_chk #(.W(W)) chk_i (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .port_rd    (port_rd),
    .port_wr    (port_wr),
    .flag_clr   (flag_clr),
    .port_rdata (port_rdata),
    .flag_o     (flag_o),
    .sync_val   (sync_q),
    .snap_val   (st_q.snap),
    .en_val     (ien_q),
    .ana_val    (asel_q)
);

// File: tb/ioc_port_monitor_tb_top.sv
module ioc_port_monitor_tb_top;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         warm_rst_n = 1'b1;
    logic [W-1:0] pins = '0;
    logic         ien_we = 1'b0;
    logic [W-1:0] ien_wdata = '0;
    logic         asel_we = 1'b0;
    logic [W-1:0] asel_wdata = '0;
    logic         port_rd = 1'b0;
    logic         port_wr = 1'b0;
    logic         flag_clr = 1'b0;
    logic         gie = 1'b1;
    logic [W-1:0] rdata;
    logic         flag;
    logic         wake;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ioc_port_monitor #(.W(W), .STAGES(2)) dut_i (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .pin_i      (pins),
        .ien_we     (ien_we),
        .ien_wdata  (ien_wdata),
        .asel_we    (asel_we),
        .asel_wdata (asel_wdata),
        .port_rd    (port_rd),
        .port_wr    (port_wr),
        .flag_clr   (flag_clr),
        .gie_i      (gie),
        .port_rdata (rdata),
        .flag_o     (flag),
        .wake_o     (wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_en(input logic [W-1:0] v);
        ien_we = 1'b1; ien_wdata = v; @(negedge clk); ien_we = 1'b0;
    endtask

    task automatic wr_ana(input logic [W-1:0] v);
        asel_we = 1'b1; asel_wdata = v; @(negedge clk); asel_we = 1'b0;
    endtask

    task automatic do_read();
        port_rd = 1'b1; @(negedge clk); port_rd = 1'b0;
    endtask

    task automatic do_write();
        port_wr = 1'b1; @(negedge clk); port_wr = 1'b0;
    endtask

    task automatic do_clr();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: power-on state, pins non-zero but all pins analog
        pins = 8'hA5;
        step(3);
        por_n = 1'b1;
        step(1);
        chk("R1 flag", flag, 0);
        chk("R1 wake", wake, 0);
        chk("R1 rdata", rdata, 0);

        // R2: read masking sweep
        wr_en('0);
        for (int k = 0; k < 16; k++) begin
            logic [W-1:0] a, p;
            a = W'((k * 37) & 8'hFF);
            p = W'((k * 91 + 3) & 8'hFF);
            wr_ana(a);
            pins = p;
            step(3);
            chk("R2", rdata, p & ~a);
        end
        // R2 latency: visible after two edges, not after one
        wr_ana('0);
        pins = 8'h00; step(3);
        pins = 8'h81; step(1);
        chk("R2 latency early", rdata, 8'h00);
        step(1);
        chk("R2 latency", rdata, 8'h81);

        // R3/R4: per-pin sweep over enable and analog combinations
        pins = '0; step(3); do_read(); do_clr(); step(1);
        for (int i = 0; i < int'(W); i++) begin
            for (int c = 0; c < 4; c++) begin
                logic en_b, an_b, exp_f;
                en_b = c[0];
                an_b = c[1];
                exp_f = en_b & ~an_b;
                wr_en(en_b ? W'(1) << i : '0);
                wr_ana(an_b ? W'(1) << i : '0);
                do_read();
                pins = W'(1) << i;
                step(3);
                chk(exp_f ? "R3 sweep" : "R4 sweep", flag, exp_f);
                chk("R9 sweep", wake, exp_f);
                pins = '0;
                step(3);
                do_read(); do_clr(); step(1);
            end
        end

        // R5/R7: clear while mismatch persists
        wr_ana('0); wr_en(8'hFF);
        pins = 8'h10; step(3);
        chk("R3", flag, 1);
        do_clr(); step(1);
        chk("R7", flag, 1);
        step(4);
        chk("R5", flag, 1);

        // R6: read refreshes snapshot, then clear works
        do_read();
        chk("R6 access keeps flag", flag, 1);
        do_clr(); step(1);
        chk("R6 read then clear", flag, 0);
        step(3);
        chk("R6 stays clear", flag, 0);

        // R6: write refreshes snapshot too
        pins = 8'h30; step(3);
        chk("R3 second", flag, 1);
        do_write(); do_clr(); step(1);
        chk("R6 write then clear", flag, 0);

        // R10: change reaches sync value exactly in the read cycle
        pins = 8'h31; step(2);
        do_read(); step(3);
        chk("R10 absorbed flag", flag, 0);
        chk("R10 rdata", rdata, 8'h31);
        // R10 contrast: read one cycle later
        pins = 8'h33; step(3);
        do_read();
        chk("R10 late read", flag, 1);
        do_clr(); step(1);
        chk("R6 clear after late read", flag, 0);

        // R9: combinational gating by gie
        pins = 8'h00; step(3);
        chk("R3 drop", flag, 1);
        gie = 1'b0; #1;
        chk("R9 gie off", wake, 0);
        gie = 1'b1; #1;
        chk("R9 gie on", wake, 1);
        do_read(); do_clr(); step(1);

        // R8: warm reset keeps snapshot
        pins = 8'h5A; step(3);
        do_read(); do_clr(); step(1);
        chk("R6 pre-warm", flag, 0);
        warm_rst_n = 1'b0; step(1); warm_rst_n = 1'b1;
        pins = 8'h00; step(3);
        chk("R8 flag after warm", flag, 0);
        chk("R8 analog after warm", rdata, 0);
        wr_ana('0); wr_en(8'hFF); step(1);
        chk("R8 snapshot kept", flag, 1);

        // R8/R1: power-on reset clears snapshot
        por_n = 1'b0; step(2); por_n = 1'b1; step(1);
        chk("R1 flag after por", flag, 0);
        wr_ana('0); wr_en(8'hFF); step(3);
        chk("R8 snapshot cleared by por", flag, 0);

        finish_run();
    end
endmodule